// File: doc/BRIEF.md
# Dual-Buffer Serial Command Front-End

This block is the serial slave side of a page-buffered flash memory. It samples the serial clock, select and data-in pins with a fast local clock, recovers edges, and assembles an 8-bit command code plus a 24-bit field. It has two jobs. First, it streams incoming bytes into either of two 264-byte SRAM buffers through their write ports. Second, it answers a status read by shifting a status byte out repeatedly, for as long as the host keeps clocking.

Program commands (buffer to main page, with or without erase) are collected in the same way. When select is released, they are passed on as a single pulse carrying the command code and page number. A separate sequencer acts on that pulse. The sequencer supplies the live busy flag, the compare result and the density code that make up the status byte.

Top module: `dbuf_spi_frontend`

## Requirements
- R1: After reset, `spi_so_oe` is 0, `buf_we` is 0 and `prog_valid` is 0.
- R2: Command 84h, then a 24-bit field (15 ignored bits, then a 9-bit start address, MSB first), then data bytes, writes each byte to buffer 0 (`buf_we` = 01). The first byte goes to the start address, and the address rises by one per byte.
- R3: Command 87h does the same into buffer 1 (`buf_we` = 10). At most one `buf_we` bit is ever high.
- R4: A write address of 263 is followed by address 0.
- R5: Loading continues until select rises. A partial byte at the select rise is not written, and the next selection starts again with a command code.
- R6: While `busy_i` is 1 when the command code completes, buffer-write and program commands have no effect. An unknown command code also has no effect.
- R7: Command D7h is accepted even while busy. It returns {~busy_i, comp_i, density_i[3:0], 2'b00}, MSB first, with each bit put out on a falling clock edge.
- R8: The status byte repeats while clocking continues. It is sampled once at the start of each repetition and held for the rest of that repetition.
- R9: `spi_so_oe` is 1 exactly while select is low.
- R10: A program command (83h, 86h, 88h, 89h) whose full 24-bit field has arrived produces a one-cycle `prog_valid` after select rises. It carries the code and the page number, which is field bits 20:9. A program command whose field is incomplete produces no `prog_valid`.
- R11: A start address of 264 or more starts the writes at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the data-out pad; when 0 the pad is high-impedance |
| busy_i | input | 1 | Sequencer busy flag |
| comp_i | input | 1 | Last compare result |
| density_i | input | 4 | Density code for status bits 5:2 |
| buf_we | output | 2 | Write strobe per buffer |
| buf_addr | output | 9 | Buffer write address |
| buf_data | output | 8 | Buffer write data |
| prog_valid | output | 1 | Program command handoff pulse |
| prog_opcode | output | 8 | Handed-off command code |
| prog_page | output | 12 | Handed-off page number |

## Verification
The bench targets three kinds of fault:
- **Address wrap at 263.** A design without the wrap writes address 264.
- **Partial byte at select rise.** A design that keeps the partial byte writes a stray byte, or misreads the next command.
- **Held status byte.** The compare input is changed between the first two bits of a status repetition. A design that shifts live bits shows a mixed byte; one that never resamples repeats the stale byte.

It also checks that busy suppresses writes and program handoff but not the status read. It sends program commands with a short field, which a careless design would hand off anyway. It uses an out-of-range start address.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
   typedef enum logic [2:0] {
      PS_OPC, PS_BADDR, PS_BDATA, PS_STAT, PS_PADDR, PS_PREADY, PS_SKIP
   } pstate_t;

   localparam logic [7:0] OP_WR_B0  = 8'h84;
   localparam logic [7:0] OP_WR_B1  = 8'h87;
   localparam logic [7:0] OP_STATUS = 8'hD7;
   localparam logic [7:0] OP_PE_B0  = 8'h83;
   localparam logic [7:0] OP_PE_B1  = 8'h86;
   localparam logic [7:0] OP_PN_B0  = 8'h88;
   localparam logic [7:0] OP_PN_B1  = 8'h89;

   localparam int FIELD_BYTES = 3;

   function automatic logic is_prog(input logic [7:0] op);
      return (op == OP_PE_B0) || (op == OP_PE_B1) ||
             (op == OP_PN_B0) || (op == OP_PN_B1);
   endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_rise,
   output logic sel,
   output logic si_s
);
   logic sck_s, cs_s;
   logic sck_d, cs_d;

   generate
      if (STAGES == 0) begin : g_direct
         assign sck_s = sck;
         assign cs_s  = cs_n;
         assign si_s  = si;
      end else begin : g_chain
         logic [STAGES-1:0] sck_q, cs_q, si_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q <= '0;
               cs_q  <= '1;
               si_q  <= '0;
            end else begin
               sck_q[0] <= sck;
               cs_q[0]  <= cs_n;
               si_q[0]  <= si;
               for (int i = 1; i < STAGES; i++) begin
                  sck_q[i] <= sck_q[i-1];
                  cs_q[i]  <= cs_q[i-1];
                  si_q[i]  <= si_q[i-1];
               end
            end
         end
         assign sck_s = sck_q[STAGES-1];
         assign cs_s  = cs_q[STAGES-1];
         assign si_s  = si_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sel      = ~cs_s;
   assign sck_rise = sel & sck_s & ~sck_d;
   assign sck_fall = sel & ~sck_s & sck_d;
   assign cs_rise  = cs_s & ~cs_d;
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
   import dbuf_pkg::*;
#(
   parameter int DEPTH  = 264,
   parameter int AW     = 9,
   parameter int PAGE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              cs_rise,
   input  logic              sel,
   input  logic              si_s,
   input  logic              busy,
   output logic [1:0]        buf_we,
   output logic [AW-1:0]     buf_addr,
   output logic [7:0]        buf_data,
   output logic              stat_active,
   output logic              prog_valid,
   output logic [7:0]        prog_opcode,
   output logic [PAGE_W-1:0] prog_page
);
   localparam int FIELD_W = 8 * FIELD_BYTES;
   localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);
   localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
   localparam logic [1:0]    FLAST   = 2'(FIELD_BYTES - 1);

   pstate_t              st;
   logic [7:0]           shreg;
   logic [2:0]           bcnt;
   logic [1:0]           fcnt;
   logic [FIELD_W-9:0]   field;
   logic                 wsel;
   logic [AW-1:0]        wr_ptr;
   logic [7:0]           nxt;
   logic [FIELD_W-1:0]   full;
   logic [AW-1:0]        start;

   assign nxt   = {shreg[6:0], si_s};
   assign full  = {field, nxt};
   assign start = full[AW-1:0];
   assign stat_active = (st == PS_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= PS_OPC;
         shreg       <= '0;
         bcnt        <= '0;
         fcnt        <= '0;
         field       <= '0;
         wsel        <= 1'b0;
         wr_ptr      <= '0;
         buf_we      <= '0;
         buf_addr    <= '0;
         buf_data    <= '0;
         prog_valid  <= 1'b0;
         prog_opcode <= '0;
         prog_page   <= '0;
      end else begin
         buf_we     <= '0;
         prog_valid <= 1'b0;
         if (cs_rise) begin
            prog_valid <= (st == PS_PREADY);
            st   <= PS_OPC;
            bcnt <= '0;
            fcnt <= '0;
         end else if (!sel) begin
            st   <= PS_OPC;
            bcnt <= '0;
            fcnt <= '0;
         end else if (sck_rise) begin
            shreg <= nxt;
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
               unique case (st)
                  PS_OPC: begin
                     fcnt <= '0;
                     if (((nxt == OP_WR_B0) || (nxt == OP_WR_B1)) && !busy) begin
                        st   <= PS_BADDR;
                        wsel <= (nxt == OP_WR_B1);
                     end else if (nxt == OP_STATUS) begin
                        st <= PS_STAT;
                     end else if (is_prog(nxt) && !busy) begin
                        st          <= PS_PADDR;
                        prog_opcode <= nxt;
                     end else begin
                        st <= PS_SKIP;
                     end
                  end
                  PS_BADDR, PS_PADDR: begin
                     field <= full[FIELD_W-9:0];
                     fcnt  <= fcnt + 2'd1;
                     if (fcnt == FLAST) begin
                        if (st == PS_BADDR) begin
                           wr_ptr <= ({1'b0, start} >= DEPTH_V) ? '0 : start;
                           st     <= PS_BDATA;
                        end else begin
                           prog_page <= full[PAGE_W+AW-1:AW];
                           st        <= PS_PREADY;
                        end
                     end
                  end
                  PS_BDATA: begin
                     buf_we   <= wsel ? 2'b10 : 2'b01;
                     buf_addr <= wr_ptr;
                     buf_data <= nxt;
                     wr_ptr   <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // R3: the two buffer strobes never fire together
   a_r3_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(buf_we));
   // R4: every write lands inside the buffer
   a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (|buf_we) |-> (buf_addr <= LAST));
   // R5: writes only come from a byte taken while selected
   a_r5_we_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (|buf_we) |-> $past(sel));
   // R10: handoff only follows a select release
   a_r10_prog_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      prog_valid |-> $past(cs_rise));
endmodule

// File: rtl/status_shifter.sv
module status_shifter #(
   parameter logic [1:0] LOW_BITS = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_fall,
   input  logic       stat_active,
   input  logic       busy,
   input  logic       comp,
   input  logic [3:0] density,
   output logic       so
);
   logic [7:0] snap;
   logic [7:0] now_v;
   logic [2:0] idx;

   assign now_v = {~busy, comp, density, LOW_BITS};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap <= '0;
         idx  <= '0;
         so   <= 1'b0;
      end else if (!stat_active) begin
         idx <= '0;
         so  <= 1'b0;
      end else if (sck_fall) begin
         if (idx == 3'd0) begin
            snap <= now_v;
            so   <= now_v[7];
         end else begin
            so <= snap[3'd7 - idx];
         end
         idx <= idx + 3'd1;
      end
   end

   // R8: data out only moves on a falling serial clock edge
   a_r8_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_active && $past(stat_active) && !$past(sck_fall)) |-> $stable(so));
endmodule

// File: rtl/dbuf_spi_frontend.sv
module dbuf_spi_frontend #(
   parameter int         BUF_DEPTH   = 264,
   parameter int         ADDR_W      = 9,
   parameter int         PAGE_W      = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [1:0] STATUS_LOW  = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   output logic              spi_so,
   output logic              spi_so_oe,
   input  logic              busy_i,
   input  logic              comp_i,
   input  logic [3:0]        density_i,
   output logic [1:0]        buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_data,
   output logic              prog_valid,
   output logic [7:0]        prog_opcode,
   output logic [PAGE_W-1:0] prog_page
);
   generate
      if (BUF_DEPTH < 2 || BUF_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("BUF_DEPTH must fit in ADDR_W bits");
      end
      if (ADDR_W + PAGE_W > 8 * dbuf_pkg::FIELD_BYTES) begin : g_bad_field
         $error("ADDR_W + PAGE_W exceeds the address field");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic sck_rise, sck_fall, cs_rise, sel, si_s, stat_active;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
      .sel(sel), .si_s(si_s)
   );

   cmd_parser #(.DEPTH(BUF_DEPTH), .AW(ADDR_W), .PAGE_W(PAGE_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
      .sel(sel), .si_s(si_s), .busy(busy_i),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .stat_active(stat_active), .prog_valid(prog_valid),
      .prog_opcode(prog_opcode), .prog_page(prog_page)
   );

   status_shifter #(.LOW_BITS(STATUS_LOW)) u_stat (
      .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .stat_active(stat_active),
      .busy(busy_i), .comp(comp_i), .density(density_i), .so(spi_so)
   );

   assign spi_so_oe = sel;
endmodule

// File: tb/tb_dbuf_spi_frontend.sv
module tb_dbuf_spi_frontend;
   localparam int H = 6;

   logic clk = 0;
   logic rst_n = 0;
   logic spi_sck = 0, spi_cs_n = 1, spi_si = 0;
   logic spi_so, spi_so_oe;
   logic busy_i = 0, comp_i = 0;
   logic [3:0] density_i = 4'b1001;
   logic [1:0] buf_we;
   logic [8:0] buf_addr;
   logic [7:0] buf_data;
   logic prog_valid;
   logic [7:0] prog_opcode;
   logic [11:0] prog_page;

   dbuf_spi_frontend dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
      .busy_i(busy_i), .comp_i(comp_i), .density_i(density_i),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .prog_valid(prog_valid), .prog_opcode(prog_opcode), .prog_page(prog_page)
   );

   always #4 clk = ~clk;

   int total = 0, fails = 0, cyc = 0, stable_n = 0, flip_at = -1;
   bit done = 0;
   logic last_cs = 1;
   logic [7:0] tx [0:15];
   logic [7:0] rx [0:15];
   logic [17:0] got_w[$], exp_w[$];
   logic [19:0] got_p[$], exp_p[$];

   task automatic check(bit ok, string req, int act, int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         total++; fails++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         summary();
         $finish;
      end
   end

   // per-clock model comparison: output enable follows a settled select (R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (buf_we != 2'b00) got_w.push_back({buf_we[1], buf_addr, buf_data});
         if (prog_valid) got_p.push_back({prog_opcode, prog_page});
         if (spi_cs_n == last_cs) stable_n++; else stable_n = 0;
         last_cs = spi_cs_n;
         if (stable_n >= 4) check(spi_so_oe == !spi_cs_n, "R9", spi_so_oe, !spi_cs_n);
      end
   end

   task automatic xfer(int n, int extra);
      int gi = 0;
      @(negedge clk); spi_cs_n = 0;
      repeat (6) @(negedge clk);
      for (int b = 0; b < n + 1; b++) begin
         for (int k = 7; k >= 0; k--) begin
            if (b == n && (7 - k) >= extra) break;
            spi_si = (b < n) ? tx[b][k] : 1'b0;
            repeat (H) @(negedge clk);
            if (b < n) rx[b][k] = spi_so;
            if (gi == flip_at) begin busy_i = 0; comp_i = 1; end
            gi++;
            spi_sck = 1;
            repeat (H) @(negedge clk);
            spi_sck = 0;
         end
      end
      repeat (H) @(negedge clk);
      spi_cs_n = 1;
      repeat (12) @(negedge clk);
   endtask

   task automatic set_wr(logic [7:0] op, int addr);
      tx[0] = op; tx[1] = 8'h00; tx[2] = 8'(addr >> 8); tx[3] = 8'(addr);
   endtask

   task automatic set_prog(logic [7:0] op, int page);
      int v = page << 9;
      tx[0] = op; tx[1] = 8'(v >> 16); tx[2] = 8'(v >> 8); tx[3] = 8'(v);
   endtask

   task automatic cmp_writes(string req);
      check(got_w.size() == exp_w.size(), req, got_w.size(), exp_w.size());
      for (int i = 0; i < got_w.size() && i < exp_w.size(); i++)
         check(got_w[i] == exp_w[i], req, got_w[i], exp_w[i]);
      got_w.delete(); exp_w.delete();
   endtask

   task automatic cmp_prog(string req);
      check(got_p.size() == exp_p.size(), req, got_p.size(), exp_p.size());
      for (int i = 0; i < got_p.size() && i < exp_p.size(); i++)
         check(got_p[i] == exp_p[i], req, got_p[i], exp_p[i]);
      got_p.delete(); exp_p.delete();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(spi_so_oe == 0, "R1 oe", spi_so_oe, 0);
      check(buf_we == 0, "R1 we", buf_we, 0);
      check(prog_valid == 0, "R1 prog", prog_valid, 0);

      // R2 buffer 0 sequential writes
      set_wr(8'h84, 5); tx[4] = 8'hA1; tx[5] = 8'hB2; tx[6] = 8'hC3;
      xfer(7, 0);
      exp_w.push_back({1'b0, 9'd5, 8'hA1});
      exp_w.push_back({1'b0, 9'd6, 8'hB2});
      exp_w.push_back({1'b0, 9'd7, 8'hC3});
      cmp_writes("R2");

      // R3 buffer 1, R4 wrap past 263
      set_wr(8'h87, 262); tx[4] = 8'h11; tx[5] = 8'h22; tx[6] = 8'h33; tx[7] = 8'h44;
      xfer(8, 0);
      exp_w.push_back({1'b1, 9'd262, 8'h11});
      exp_w.push_back({1'b1, 9'd263, 8'h22});
      exp_w.push_back({1'b1, 9'd0, 8'h33});
      exp_w.push_back({1'b1, 9'd1, 8'h44});
      cmp_writes("R3 R4");

      // R5 partial byte dropped, parser restarts
      set_wr(8'h84, 10); tx[4] = 8'hAA; tx[5] = 8'hBB;
      xfer(6, 3);
      exp_w.push_back({1'b0, 9'd10, 8'hAA});
      exp_w.push_back({1'b0, 9'd11, 8'hBB});
      cmp_writes("R5 partial");
      set_wr(8'h87, 0); tx[4] = 8'h5A;
      xfer(5, 0);
      exp_w.push_back({1'b1, 9'd0, 8'h5A});
      cmp_writes("R5 restart");

      // R6 busy suppresses writes and program; unknown opcode ignored
      busy_i = 1;
      set_wr(8'h84, 0); tx[4] = 8'h01; tx[5] = 8'h02;
      xfer(6, 0);
      set_prog(8'h83, 12'h123);
      xfer(4, 0);
      busy_i = 0;
      tx[0] = 8'h55; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00; tx[4] = 8'h77;
      xfer(5, 0);
      cmp_writes("R6");
      cmp_prog("R6");

      // R7 status while busy, R8 per-repetition snapshot
      busy_i = 1; comp_i = 0; flip_at = 8;
      tx[0] = 8'hD7; tx[1] = 0; tx[2] = 0; tx[3] = 0;
      xfer(4, 0);
      flip_at = -1;
      check(rx[1] == 8'h24, "R7 status busy", rx[1], 8'h24);
      check(rx[2] == 8'hE4, "R8 second repetition", rx[2], 8'hE4);
      check(rx[3] == 8'hE4, "R8 third repetition", rx[3], 8'hE4);
      comp_i = 0;
      cmp_writes("R7 no write");

      // R10 program handoff, and incomplete field
      set_prog(8'h86, 12'hABC); tx[4] = 8'hFF;
      xfer(5, 0);
      exp_p.push_back({8'h86, 12'hABC});
      cmp_prog("R10 handoff");
      set_prog(8'h88, 12'h321);
      xfer(3, 0);
      cmp_prog("R10 incomplete");

      // R11 out-of-range start address
      set_wr(8'h84, 300); tx[4] = 8'h11; tx[5] = 8'h22;
      xfer(6, 0);
      exp_w.push_back({1'b0, 9'd0, 8'h11});
      exp_w.push_back({1'b0, 9'd1, 8'h22});
      cmp_writes("R11");

      done = 1;
      summary();
      $finish;
   end
endmodule